// File: doc/BRIEF.md
# Software-Managed Address Translation Buffer

This block turns 32-bit virtual addresses into physical addresses for 4 KB pages. It holds 64 fully associative entries and is filled only by software. The low 12 address bits are the page offset and pass through unchanged. The upper 20 bits form the virtual page number, which is compared against every entry at once. The data path drives a lookup port with the address, the current process ID, a store flag and a user-mode flag. One cycle later the port returns the physical address, a non-cacheable flag, and miss, modify-fault and address-error indications.

The system-control side uses four registers: a tag register, a data register, an index register and a free-running replacement pointer. Software writes the tag and data registers and then issues an operation. The operation can write an entry at the index register, write an entry at the pointer, read an entry back into the tag and data registers, or probe for the entry that matches the tag register. The pointer never selects entries 0 to 7, so software can pin mappings there that a refill handler choosing victims by the pointer cannot evict.

Top module: `xlate_buf`

## Requirements
- R1: After a synchronous reset, the pointer reads 63. The tag, data and index registers read 0. Every lookup output is 0, and every entry is invalid, so any lookup misses.
- R2: The pointer decrements on every clock that is not a reset clock. It wraps from 8 back to 63 and always holds a value between 8 and 63.
- R3: Register layout:
  - Tag register: VPN in bits 25:6, PID in bits 5:0.
  - Data register: PFN in bits 23:4, N (non-cacheable) in bit 3, D (dirty) in bit 2, V (valid) in bit 1, G (global) in bit 0.
  - Index register: entry number in bits 5:0, probe-failed flag in bit 6.
  - Operation code: 0 none, 1 read, 2 write at the index register, 3 write at the pointer, 4 probe.
  - After a write by index followed by a read of the same index, the tag and data registers hold exactly what was written. They show it in the cycle after the read operation.
- R4: A write at the pointer stores the tag and data registers into the entry the pointer names at that clock. Entries 0 to 7 are never altered by such writes.
- R5: On a lookup hit that is not faulted, the physical address equals {PFN, vaddr[11:0]} and the non-cacheable output equals N. All lookup outputs are presented in the cycle after the request, with the done flag set.
- R6: An entry hits only when its VPN equals vaddr[31:12] and either its PID equals the lookup PID or its G bit is set.
- R7: An entry whose V bit is clear never hits, in a lookup or in a probe.
- R8: A lookup with no hitting entry that has no address error raises miss. In that case the physical address and the non-cacheable output are 0.
- R9: A user-mode lookup with vaddr[31]=1 raises address error whether or not an entry hits. Miss and modify fault then stay low, and the physical address is 0. A lookup not in user mode to the same region translates normally.
- R10: A store that hits an entry with D clear raises modify fault. The physical address and the non-cacheable output are then 0. A load to the same entry completes normally.
- R11: A probe loads the index register with {0, entry number} of the hitting entry, or with 0x40 when no entry matches the tag register.
- R12: When several entries hit, both lookup and probe pick the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 6 | Current process ID |
| lk_store | input | 1 | Access is a store |
| lk_user | input | 1 | Access is made in user mode |
| hi_we | input | 1 | Write the tag register |
| hi_wdata | input | 26 | New tag register value |
| lo_we | input | 1 | Write the data register |
| lo_wdata | input | 24 | New data register value |
| idx_we | input | 1 | Write the index register |
| idx_wdata | input | 7 | New index register value |
| op | input | 3 | Control operation code |
| lk_done | output | 1 | Lookup result valid |
| lk_paddr | output | 32 | Translated physical address |
| lk_nocache | output | 1 | Page is non-cacheable |
| lk_miss | output | 1 | No translation found |
| lk_modfault | output | 1 | Store to a clean page |
| lk_adderr | output | 1 | User access to the system region |
| hi_q | output | 26 | Tag register |
| lo_q | output | 24 | Data register |
| idx_q | output | 7 | Index register |
| rnd_q | output | 6 | Replacement pointer |

## Verification
The bench builds the block with its default 64 entries and 8 protected entries. At these values the pointer's wrap from 8 to 63 is reached within a few dozen cycles. More than fifty writes at the pointer can run against entries 0 to 7 to show they stay untouched. Random traffic draws page numbers and process IDs from a small pool, so duplicate entries, global matches and PID mismatches all occur across the full 64-entry array. This exercises the lowest-index choice.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VPN_W = 20;
  localparam int PID_W = 6;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
  } tag_t;

  typedef struct packed {
    logic [VPN_W-1:0] pfn;
    logic             n;
    logic             d;
    logic             v;
    logic             g;
  } dat_t;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WIDX  = 3'd2,
    OP_WRND  = 3'd3,
    OP_PROBE = 3'd4
  } op_e;
endpackage

// File: rtl/xlate_rand.sv
module xlate_rand #(
  parameter int ENTRIES = 64,
  parameter int SAFE    = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] rnd
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] LOW = IDX_W'(SAFE);

  always_ff @(posedge clk) begin
    if (rst)             rnd <= TOP;
    else if (rnd == LOW) rnd <= TOP;
    else                 rnd <= rnd - 1'b1;
  end

  AST_RND_RANGE: assert property (@(posedge clk) disable iff (rst) (rnd >= LOW) && (rnd <= TOP)); // R2
  AST_RND_WRAP: assert property (@(posedge clk) disable iff (rst) (rnd == LOW) |=> (rnd == TOP)); // R2
endmodule

// File: rtl/xlate_match.sv
module xlate_match
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  tag_t               ent_tag [ENTRIES],
  input  logic [ENTRIES-1:0] ent_v,
  input  logic [ENTRIES-1:0] ent_g,
  input  logic [VPN_W-1:0]   key_vpn,
  input  logic [PID_W-1:0]   key_pid,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);
  logic [ENTRIES-1:0] mvec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign mvec[i] = ent_v[i] && (ent_tag[i].vpn == key_vpn) &&
                     ((ent_tag[i].pid == key_pid) || ent_g[i]);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (mvec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |mvec;

  always_comb begin
    if (hit) begin
      AST_HIT_VALID: assert (ent_v[hit_idx]); // R7
      AST_LOWEST: assert ((mvec & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0); // R12
    end
  end
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int SAFE    = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = VPN_W + PID_W,
  localparam int DAT_W  = VPN_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req,
  input  logic [31:0]      lk_vaddr,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             lk_store,
  input  logic             lk_user,
  input  logic             hi_we,
  input  logic [TAG_W-1:0] hi_wdata,
  input  logic             lo_we,
  input  logic [DAT_W-1:0] lo_wdata,
  input  logic             idx_we,
  input  logic [IDX_W:0]   idx_wdata,
  input  logic [2:0]       op,
  output logic             lk_done,
  output logic [31:0]      lk_paddr,
  output logic             lk_nocache,
  output logic             lk_miss,
  output logic             lk_modfault,
  output logic             lk_adderr,
  output logic [TAG_W-1:0] hi_q,
  output logic [DAT_W-1:0] lo_q,
  output logic [IDX_W:0]   idx_q,
  output logic [IDX_W-1:0] rnd_q
);
  tag_t               ent_tag [ENTRIES];
  dat_t               ent_dat [ENTRIES];
  logic [ENTRIES-1:0] ent_v, ent_g;
  op_e                op_c;
  tag_t               hi_s;
  logic               lk_hit, pr_hit;
  logic [IDX_W-1:0]   lk_idx, pr_idx, wr_idx;
  logic               wr_en;

  assign op_c = op_e'(op);
  assign hi_s = tag_t'(hi_q);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_flags
    assign ent_v[i] = ent_dat[i].v;
    assign ent_g[i] = ent_dat[i].g;
  end

  xlate_rand #(.ENTRIES(ENTRIES), .SAFE(SAFE)) i_rand (
    .clk(clk), .rst(rst), .rnd(rnd_q)
  );

  xlate_match #(.ENTRIES(ENTRIES)) i_lk_match (
    .ent_tag(ent_tag), .ent_v(ent_v), .ent_g(ent_g),
    .key_vpn(lk_vaddr[31:12]), .key_pid(lk_pid),
    .hit(lk_hit), .hit_idx(lk_idx)
  );

  xlate_match #(.ENTRIES(ENTRIES)) i_pr_match (
    .ent_tag(ent_tag), .ent_v(ent_v), .ent_g(ent_g),
    .key_vpn(hi_s.vpn), .key_pid(hi_s.pid),
    .hit(pr_hit), .hit_idx(pr_idx)
  );

  // Entry array write port: indexed or pointer-selected.
  assign wr_en  = (op_c == OP_WIDX) || (op_c == OP_WRND);
  assign wr_idx = (op_c == OP_WRND) ? rnd_q : idx_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_tag[i] <= '0;
        ent_dat[i] <= '0;
      end
    end else if (wr_en) begin
      ent_tag[wr_idx] <= tag_t'(hi_q);
      ent_dat[wr_idx] <= dat_t'(lo_q);
    end
  end

  // Control registers: operation results win over software writes.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      idx_q <= '0;
    end else begin
      if (hi_we)  hi_q  <= hi_wdata;
      if (lo_we)  lo_q  <= lo_wdata;
      if (idx_we) idx_q <= idx_wdata;
      if (op_c == OP_READ) begin
        hi_q <= ent_tag[idx_q[IDX_W-1:0]];
        lo_q <= ent_dat[idx_q[IDX_W-1:0]];
      end
      if (op_c == OP_PROBE) begin
        idx_q <= pr_hit ? {1'b0, pr_idx} : {1'b1, {IDX_W{1'b0}}};
      end
    end
  end

  // Registered lookup result.
  logic  aerr_c, ok_c, mf_c;
  dat_t  hd_c;
  assign hd_c   = ent_dat[lk_idx];
  assign aerr_c = lk_user && lk_vaddr[31];
  assign mf_c   = !aerr_c && lk_hit && lk_store && !hd_c.d;
  assign ok_c   = !aerr_c && lk_hit && !mf_c;

  always_ff @(posedge clk) begin
    if (rst || !lk_req) begin
      lk_done     <= 1'b0;
      lk_paddr    <= '0;
      lk_nocache  <= 1'b0;
      lk_miss     <= 1'b0;
      lk_modfault <= 1'b0;
      lk_adderr   <= 1'b0;
    end else begin
      lk_done     <= 1'b1;
      lk_paddr    <= ok_c ? {hd_c.pfn, lk_vaddr[11:0]} : 32'd0;
      lk_nocache  <= ok_c && hd_c.n;
      lk_miss     <= !aerr_c && !lk_hit;
      lk_modfault <= mf_c;
      lk_adderr   <= aerr_c;
    end
  end

  AST_ADDR_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) lk_adderr |-> (!lk_miss && !lk_modfault && lk_paddr == 32'd0)); // R9
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst) lk_miss |-> (lk_paddr == 32'd0 && !lk_nocache)); // R8
  AST_MODF_ZERO: assert property (@(posedge clk) disable iff (rst) lk_modfault |-> (lk_paddr == 32'd0 && !lk_nocache)); // R10
  AST_OFFSET: assert property (@(posedge clk) disable iff (rst) lk_req && !aerr_c && lk_hit && !mf_c |=> (lk_paddr[11:0] == $past(lk_vaddr[11:0]))); // R5
  AST_RND_WRITE_SAFE: assert property (@(posedge clk) disable iff (rst) (op_c == OP_WRND) |-> (rnd_q >= IDX_W'(SAFE))); // R4
  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0({lk_miss, lk_modfault, lk_adderr})); // R8
endmodule

// File: tb/test_xlate_buf.sv
module test_xlate_buf;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_req, lk_store, lk_user, hi_we, lo_we, idx_we;
  logic [31:0] lk_vaddr;
  logic [5:0]  lk_pid;
  logic [25:0] hi_wdata;
  logic [23:0] lo_wdata;
  logic [6:0]  idx_wdata;
  logic [2:0]  op;
  logic        lk_done, lk_nocache, lk_miss, lk_modfault, lk_adderr;
  logic [31:0] lk_paddr;
  logic [25:0] hi_q;
  logic [23:0] lo_q;
  logic [6:0]  idx_q;
  logic [5:0]  rnd_q;

  int errors = 0;
  int checks = 0;
  logic [25:0] m_tag [64];
  logic [23:0] m_dat [64];
  int rnd_m;

  always #(CLK_P/2) clk = ~clk;

  xlate_buf i_xlate_buf (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .lk_store(lk_store), .lk_user(lk_user), .hi_we(hi_we), .hi_wdata(hi_wdata),
    .lo_we(lo_we), .lo_wdata(lo_wdata), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .op(op), .lk_done(lk_done), .lk_paddr(lk_paddr), .lk_nocache(lk_nocache),
    .lk_miss(lk_miss), .lk_modfault(lk_modfault), .lk_adderr(lk_adderr),
    .hi_q(hi_q), .lo_q(lo_q), .idx_q(idx_q), .rnd_q(rnd_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    rnd_m = (rnd_m == 8) ? 63 : rnd_m - 1;
    @(negedge clk);
    hi_we = 0; lo_we = 0; idx_we = 0; op = 0; lk_req = 0;
  endtask

  task automatic set_regs(input logic [25:0] t, input logic [23:0] d, input int idx);
    hi_we = 1; hi_wdata = t; lo_we = 1; lo_wdata = d;
    idx_we = 1; idx_wdata = 7'(idx);
    step();
  endtask

  task automatic write_idx(input int i, input logic [25:0] t, input logic [23:0] d);
    set_regs(t, d, i);
    op = 3'd2; m_tag[i] = t; m_dat[i] = d;
    step();
  endtask

  task automatic write_rnd(input logic [25:0] t, input logic [23:0] d);
    hi_we = 1; hi_wdata = t; lo_we = 1; lo_wdata = d;
    step();
    op = 3'd3; m_tag[rnd_m] = t; m_dat[rnd_m] = d;
    step();
  endtask

  function automatic int find(input logic [19:0] vpn, input logic [5:0] pid);
    for (int i = 0; i < 64; i++)
      if (m_dat[i][1] && m_tag[i][25:6] == vpn && (m_tag[i][5:0] == pid || m_dat[i][0]))
        return i;
    return -1;
  endfunction

  task automatic lookup(input string req, input logic [31:0] va, input logic [5:0] pid,
                        input logic st, input logic usr);
    int h;
    logic ae, ms, mf;
    logic [31:0] pa;
    logic nc;
    lk_req = 1; lk_vaddr = va; lk_pid = pid; lk_store = st; lk_user = usr;
    step();
    h = find(va[31:12], pid);
    ae = usr && va[31];
    ms = !ae && h < 0;
    mf = !ae && h >= 0 && st && !m_dat[h][2];
    pa = 0; nc = 0;
    if (!ae && h >= 0 && !mf) begin
      pa = {m_dat[h][23:4], va[11:0]};
      nc = m_dat[h][3];
    end
    chk({req, " done"}, 32'(lk_done), 1);
    chk({req, " paddr"}, lk_paddr, pa);
    chk({req, " flags"}, {28'd0, nc, ms, mf, ae},
        {28'd0, lk_nocache, lk_miss, lk_modfault, lk_adderr});
  endtask

  task automatic probe(input string req, input logic [25:0] t);
    int h;
    hi_we = 1; hi_wdata = t;
    step();
    op = 3'd4;
    step();
    h = find(t[25:6], t[5:0]);
    chk(req, 32'(idx_q), (h < 0) ? 32'h40 : 32'(h));
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst = 1; hi_we = 0; lo_we = 0; idx_we = 0; op = 0; lk_req = 0;
    lk_vaddr = 0; lk_pid = 0; lk_store = 0; lk_user = 0;
    hi_wdata = 0; lo_wdata = 0; idx_wdata = 0;
    for (int i = 0; i < 64; i++) begin m_tag[i] = 0; m_dat[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0; rnd_m = 63;

    // R1: reset state
    chk("R1 rnd", 32'(rnd_q), 63);
    chk("R1 regs", {hi_q[5:0], lo_q, idx_q}, 0);
    chk("R1 outputs", {26'd0, lk_done, lk_nocache, lk_miss, lk_modfault, lk_adderr, |lk_paddr}, 0);
    lookup("R1 empty", 32'h0000_0123, 0, 0, 0);

    // R2: pointer decrement and wrap
    for (int i = 0; i < 70; i++) begin
      step();
      chk("R2 rnd", 32'(rnd_q), 32'(rnd_m));
    end

    // R3: indexed write and readback
    write_idx(5, {20'hABCDE, 6'd3}, {20'h12345, 4'b1110});
    idx_we = 1; idx_wdata = 7'd5; step();
    op = 3'd1; step();
    chk("R3 tag read", 32'(hi_q), {6'd0, 20'hABCDE, 6'd3});
    chk("R3 data read", 32'(lo_q), {8'd0, 20'h12345, 4'b1110});

    // R5/R6: hit, PID, global
    lookup("R5 hit", 32'hABCDE_7F1, 3, 0, 0);
    lookup("R6 pid mismatch", 32'hABCDE_7F1, 4, 0, 0);
    write_idx(6, {20'h00777, 6'd9}, {20'h0BEEF, 4'b0111});
    lookup("R6 global", 32'h00777_002, 33, 1, 0);

    // R7: invalid entry never hits
    write_idx(7, {20'h00888, 6'd1}, {20'h0CAFE, 4'b1101});
    lookup("R7 invalid", 32'h00888_000, 1, 0, 0);
    probe("R7 probe invalid", {20'h00888, 6'd1});

    // R9: user access to system region
    write_idx(4, {20'hC0000, 6'd2}, {20'h00042, 4'b0110});
    lookup("R9 user sys", 32'hC0000_010, 2, 0, 1);
    lookup("R9 kernel sys", 32'hC0000_010, 2, 0, 0);
    lookup("R9 user miss", 32'hF0000_010, 2, 0, 1);

    // R10: store to clean page
    write_idx(3, {20'h00999, 6'd2}, {20'h00055, 4'b1010});
    lookup("R10 store clean", 32'h00999_abc, 2, 1, 0);
    lookup("R10 load clean", 32'h00999_abc, 2, 0, 0);

    // R11/R12: probe and lowest index
    write_idx(20, {20'h05555, 6'd7}, {20'h00020, 4'b0110});
    write_idx(10, {20'h05555, 6'd7}, {20'h00010, 4'b0110});
    lookup("R12 lowest", 32'h05555_444, 7, 1, 0);
    probe("R12 probe lowest", {20'h05555, 6'd7});
    probe("R11 probe miss", {20'h0DEAD, 6'd7});

    // R4: pointer writes leave entries 0..7 alone
    for (int i = 0; i < 60; i++) write_rnd({20'h30000 + 20'(i), 6'd1}, {20'(i), 4'b0110});
    for (int i = 0; i < 8; i++) begin
      idx_we = 1; idx_wdata = 7'(i); step();
      op = 3'd1; step();
      chk("R4 protected tag", 32'(hi_q), 32'(m_tag[i]));
      chk("R4 protected data", 32'(lo_q), 32'(m_dat[i]));
    end
    lookup("R4 rnd target", 32'h3003B_000, 1, 0, 0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int k = int'($urandom_range(0, 9));
      logic [25:0] t = {20'($urandom_range(0, 11)), 6'($urandom_range(0, 3))};
      logic [23:0] d = {20'($urandom), 4'($urandom)};
      if (k < 2) write_idx(int'($urandom_range(0, 63)), t, d);
      else if (k < 4) write_rnd(t, d);
      else if (k < 5) probe("R11 random probe", t);
      else lookup("R6 random lookup", {1'($urandom), 19'($urandom_range(0, 11)), 12'($urandom)},
                  6'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
      chk("R2 rnd track", 32'(rnd_q), 32'(rnd_m));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule